// File: doc/BRIEF.md
# Two-wire slave with command-byte register access

This block is a slave on a two-wire serial bus (I2C). It watches the open-drain clock and data lines through synchronizers clocked by a much faster system clock. It answers one fixed 7-bit device address. After that address it turns the bus traffic into single-cycle read and write strobes for a register file outside the block. The register storage and any time counters sit in the surrounding core. The block only supplies the register space, the index, the write data and the strobes, and it takes back the read data.

A write transfer sends the device address with direction 0 and then one command byte. The command byte's MSB must be 1 for writes to take effect. Bit 6 picks the space: 0 is the clock/calendar registers and 1 is the RAM. Bits 5..1 give the starting index, and bit 0 gives the direction of the data that follows. Any number of data bytes may follow the command. The index steps after every byte and wraps inside the selected space. A read can start straight after a command byte whose bit 0 is 1. A read can also start from an address byte with direction 1, which continues from wherever the index was left.

Top module: `tkp_regport`

## Requirements
- R1: After reset the SDA drive enable is low, and neither the write strobe nor the read strobe is asserted until a transfer requests it.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START at any point makes the slave wait for an address byte. A STOP at any point makes it idle. A partly shifted byte is dropped and causes no register access.
- R3: The first byte after START is compared MSB first: bits 7..1 against SLAVE_ADDR (default 7'b1101000), with bit 0 as the direction (1 = read). On a match the slave pulls SDA low for the acknowledge clock. On a mismatch it never drives SDA and ignores all traffic until the next START.
- R4: After a matching address with direction 0, the next byte is the command byte, and the slave acknowledges it. Bit 7 is the write enable, bit 6 is the space (0 = clock/calendar, 1 = RAM), bits 5..1 are the start index, and bit 0 is the data direction (0 = write, 1 = read).
- R5: Every data byte written after a command with bit 0 = 0 is acknowledged, with no limit on their number. When writes are enabled, each byte produces one single-cycle write strobe carrying its space, index and data.
- R6: When command bit 7 is 0, written data bytes are still acknowledged but produce no write strobe.
- R7: After each register access the index moves up by one. After index CLK_REGS-1 in the clock space, or RAM_REGS-1 in the RAM space, it wraps to 0, and an index loaded beyond that limit also wraps to 0 after its access.
- R8: After acknowledging a command byte with bit 0 = 1, the slave sends the register at the commanded index MSB first. It raises the read strobe for one cycle and takes the read data in that same cycle.
- R9: While sending, a master acknowledge (SDA low on the ninth clock) makes the slave fetch and send the next register. A missing acknowledge makes the slave release SDA and stop sending.
- R10: A matching address with direction 1 makes the slave send at once from the retained space and index, without a command byte.
- R11: The slave changes its SDA drive only while SCL is low, except for releasing SDA on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Level of the SCL line |
| sda_i | input | 1 | Level of the SDA line |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| reg_wr_o | output | 1 | Single-cycle register write strobe |
| reg_rd_o | output | 1 | Single-cycle register read strobe |
| reg_space_o | output | 1 | Selected space: 0 clock/calendar, 1 RAM |
| reg_idx_o | output | 5 | Register index for the current access |
| reg_wdata_o | output | 8 | Write data, valid with reg_wr_o |
| reg_rdata_i | input | 8 | Read data, sampled in the cycle reg_rd_o is high |

## Verification
The bench builds the block with CLK_REGS set to 8 and RAM_REGS left at 32. This puts the end of the clock space at index 7, so a two-byte burst that starts there shows the wrap to index 0. The end of the RAM space is reached both by a 31-to-0 read and by a ten-byte write burst that starts at index 28. SYNC_STAGES stays at 2 and SLAVE_ADDR at its default, so the address byte used on the bus is 0xD0 for writes and 0xD1 for reads.

// File: rtl/tkp_pkg.sv
// Shared definitions for the two-wire command-byte register port.
// Assumes a 5-bit register index carried in command bits 5..1.
package tkp_pkg;

    localparam int TK_IDX_W = 5;

    typedef enum logic [2:0] {
        TK_IDLE = 3'd0,
        TK_ADDR = 3'd1,
        TK_CMD  = 3'd2,
        TK_WR   = 3'd3,
        TK_RD   = 3'd4
    } tk_state_e;

endpackage

// File: rtl/tkp_sync_bit.sv
// Synchronizes one asynchronous line level into the clk domain and
// keeps a one-cycle-delayed copy for edge detection.
// Assumes the line idles high, so every stage resets to 1.
module tkp_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic q_d
);

    logic [STAGES-1:0] chain;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    // Hold the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) q_d <= 1'b1;
        else        q_d <= chain[STAGES-1];
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/tkp_line_sync.sv
// Brings SCL and SDA into the clk domain and derives SCL edges and
// bus START/STOP conditions from the synchronized levels.
// Assumes clk runs at least ~10x faster than SCL.
module tkp_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] lvl_d;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        tkp_sync_bit #(.STAGES(STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw[g]),
            .q    (lvl[g]),
            .q_d  (lvl_d[g])
        );
    end

    logic scl_d, sda_d;
    assign scl_s = lvl[1];
    assign sda_s = lvl[0];
    assign scl_d = lvl_d[1];
    assign sda_d = lvl_d[0];

    // Edge and bus-condition decode from current and previous levels.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        bus_start = scl_s & scl_d & sda_d & ~sda_s;
        bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/tkp_ptr.sv
// Holds the selected register space and index, loads them from a
// command byte and steps the index after each access with wrap.
// Assumes CLK_REGS and RAM_REGS lie in 1..32.
module tkp_ptr
    import tkp_pkg::*;
#(
    parameter int CLK_REGS = 16,
    parameter int RAM_REGS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                load_space,
    input  logic [TK_IDX_W-1:0] load_idx,
    input  logic                step,
    output logic                space_o,
    output logic [TK_IDX_W-1:0] idx_o
);

    localparam logic [TK_IDX_W-1:0] CLK_LAST = TK_IDX_W'(CLK_REGS - 1);
    localparam logic [TK_IDX_W-1:0] RAM_LAST = TK_IDX_W'(RAM_REGS - 1);

    logic [TK_IDX_W-1:0] last;
    assign last = space_o ? RAM_LAST : CLK_LAST;

    // Load from the command byte or advance with wrap after an access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            space_o <= 1'b0;
            idx_o   <= '0;
        end else if (load) begin
            space_o <= load_space;
            idx_o   <= load_idx;
        end else if (step) begin
            idx_o <= (idx_o >= last) ? '0 : idx_o + 1'b1;
        end
    end

endmodule

// File: rtl/tkp_regport.sv
// Two-wire bus slave: address match, command-byte decode, burst
// register writes and reads through a single-cycle strobe port.
// Assumes an open-drain pad (sda_oe_o pulls low), a combinational
// read path (reg_rdata_i valid in the reg_rd_o cycle), no stretching.
module tkp_regport
    import tkp_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'b1101000,
    parameter int         CLK_REGS    = 16,
    parameter int         RAM_REGS    = 32,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe_o,
    output logic                reg_wr_o,
    output logic                reg_rd_o,
    output logic                reg_space_o,
    output logic [TK_IDX_W-1:0] reg_idx_o,
    output logic [7:0]          reg_wdata_o,
    input  logic [7:0]          reg_rdata_i
);

    localparam logic [3:0] BYTE_BITS = 4'd8;

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

    tkp_line_sync #(.STAGES(SYNC_STAGES)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop)
    );

    tk_state_e  state;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic       in_ack;
    logic       in_mack;
    logic       mack_ok;
    logic       we_en;
    logic       cmd_rd;
    logic       addr_rd;

    logic rx_state, byte_done, ack_end, enter_rd, mack_next, cmd_load;

    // Decode the byte-level events that drive the strobes and pointer.
    always_comb begin
        rx_state  = (state == TK_ADDR) || (state == TK_CMD) || (state == TK_WR);
        byte_done = rx_state && scl_fall && !in_ack && (bitcnt == BYTE_BITS);
        ack_end   = rx_state && scl_fall && in_ack;
        enter_rd  = ack_end && (((state == TK_ADDR) && addr_rd) ||
                                ((state == TK_CMD) && cmd_rd));
        mack_next = (state == TK_RD) && scl_fall && in_mack && mack_ok;
        cmd_load  = byte_done && (state == TK_CMD);
        reg_rd_o  = enter_rd || mack_next;
        reg_wr_o  = byte_done && (state == TK_WR) && we_en;
    end

    assign reg_wdata_o = shreg;

    tkp_ptr #(.CLK_REGS(CLK_REGS), .RAM_REGS(RAM_REGS)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cmd_load),
        .load_space(shreg[6]),
        .load_idx  (shreg[5:1]),
        .step      (reg_rd_o | reg_wr_o),
        .space_o   (reg_space_o),
        .idx_o     (reg_idx_o)
    );

    // Bus protocol sequencer: shifting, acknowledge and transmit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= TK_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            in_ack   <= 1'b0;
            in_mack  <= 1'b0;
            mack_ok  <= 1'b0;
            we_en    <= 1'b0;
            cmd_rd   <= 1'b0;
            addr_rd  <= 1'b0;
            sda_oe_o <= 1'b0;
        end else if (bus_start || bus_stop) begin
            state    <= bus_start ? TK_ADDR : TK_IDLE;
            bitcnt   <= '0;
            in_ack   <= 1'b0;
            in_mack  <= 1'b0;
            sda_oe_o <= 1'b0;
        end else if (rx_state) begin
            if (scl_rise && !in_ack) begin
                shreg  <= {shreg[6:0], sda_s};
                bitcnt <= bitcnt + 4'd1;
            end
            if (byte_done) begin
                bitcnt <= '0;
                if (state == TK_ADDR && shreg[7:1] != SLAVE_ADDR) begin
                    state <= TK_IDLE;
                end else begin
                    in_ack   <= 1'b1;
                    sda_oe_o <= 1'b1;
                    if (state == TK_ADDR) addr_rd <= shreg[0];
                    if (state == TK_CMD) begin
                        we_en  <= shreg[7];
                        cmd_rd <= shreg[0];
                    end
                end
            end
            if (ack_end) begin
                in_ack   <= 1'b0;
                sda_oe_o <= 1'b0;
                if (enter_rd) begin
                    state    <= TK_RD;
                    shreg    <= reg_rdata_i;
                    sda_oe_o <= ~reg_rdata_i[7];
                end else if (state == TK_ADDR) begin
                    state <= TK_CMD;
                end else if (state == TK_CMD) begin
                    state <= TK_WR;
                end
            end
        end else if (state == TK_RD) begin
            if (!in_mack) begin
                if (scl_rise) bitcnt <= bitcnt + 4'd1;
                if (scl_fall) begin
                    if (bitcnt == BYTE_BITS) begin
                        in_mack  <= 1'b1;
                        sda_oe_o <= 1'b0;
                        bitcnt   <= '0;
                    end else begin
                        shreg    <= {shreg[6:0], 1'b0};
                        sda_oe_o <= ~shreg[6];
                    end
                end
            end else begin
                if (scl_rise) mack_ok <= ~sda_s;
                if (scl_fall) begin
                    if (mack_ok) begin
                        in_mack  <= 1'b0;
                        shreg    <= reg_rdata_i;
                        sda_oe_o <= ~reg_rdata_i[7];
                    end else begin
                        state <= TK_IDLE;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tkp_regport_chk.sv
// Property checker for tkp_regport, attached with bind below.
// Assumes it sees the top's synchronized SCL level and bus conditions.
module tkp_regport_chk
    import tkp_pkg::*;
#(
    parameter int CLK_REGS = 16,
    parameter int RAM_REGS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                scl_s,
    input logic                bus_start,
    input logic                bus_stop,
    input tk_state_e           state,
    input logic                sda_oe_o,
    input logic                reg_wr_o,
    input logic                reg_rd_o,
    input logic                reg_space_o,
    input logic [TK_IDX_W-1:0] reg_idx_o
);

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TK_IDLE) |-> !sda_oe_o); // R1

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (!sda_oe_o && state == TK_IDLE)); // R2

    AST_WR_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> sda_oe_o); // R5

    AST_IDX_WRAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_o || reg_rd_o) |=>
            (reg_space_o ? (int'(reg_idx_o) < RAM_REGS)
                         : (int'(reg_idx_o) < CLK_REGS))); // R7

    AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && !bus_start && !bus_stop) |=> (sda_oe_o == $past(sda_oe_o))); // R11

endmodule

bind tkp_regport tkp_regport_chk #(
    .CLK_REGS(CLK_REGS),
    .RAM_REGS(RAM_REGS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .bus_start  (bus_start),
    .bus_stop   (bus_stop),
    .state      (state),
    .sda_oe_o   (sda_oe_o),
    .reg_wr_o   (reg_wr_o),
    .reg_rd_o   (reg_rd_o),
    .reg_space_o(reg_space_o),
    .reg_idx_o  (reg_idx_o)
);

// File: tb/tkp_regport_tb_top.sv
// Self-checking bench: bus master tasks, an external register model,
// a vector table of write bursts, then directed read and abort tests.
module tkp_regport_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  QTR        = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe_o, reg_wr_o, reg_rd_o, reg_space_o;
    logic [4:0] reg_idx_o;
    logic [7:0] reg_wdata_o, reg_rdata_i;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign sda_line = sda_m & ~sda_oe_o;

    tkp_regport #(.CLK_REGS(8), .RAM_REGS(32)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe_o),
        .reg_wr_o   (reg_wr_o),
        .reg_rd_o   (reg_rd_o),
        .reg_space_o(reg_space_o),
        .reg_idx_o  (reg_idx_o),
        .reg_wdata_o(reg_wdata_o),
        .reg_rdata_i(reg_rdata_i)
    );

    // External register storage model with write counter and drive monitor.
    logic [7:0] mdl_clk [32];
    logic [7:0] mdl_ram [32];
    logic       mdl_clear = 1'b0;
    int         wr_cnt;
    logic       oe_seen;

    always @(posedge clk) begin
        if (mdl_clear) begin
            for (int i = 0; i < 32; i++) begin
                mdl_clk[i] <= 8'h40 + 8'(i);
                mdl_ram[i] <= 8'h80 + 8'(i);
            end
            wr_cnt  <= 0;
            oe_seen <= 1'b0;
        end else begin
            if (reg_wr_o) begin
                if (reg_space_o) mdl_ram[reg_idx_o] <= reg_wdata_o;
                else             mdl_clk[reg_idx_o] <= reg_wdata_o;
            end
            wr_cnt <= wr_cnt + (reg_wr_o ? 1 : 0);
            if (sda_oe_o) oe_seen <= 1'b1;
        end
    end

    assign reg_rdata_i = reg_space_o ? mdl_ram[reg_idx_o] : mdl_clk[reg_idx_o];

    int n_chk  = 0;
    int n_fail = 0;
    int hold_err = 0;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_model();
        mdl_clear = 1'b1;
        tick(1);
        mdl_clear = 1'b0;
        tick(1);
    endtask

    task automatic m_start();
        sda_m = 1'b1; tick(QTR);
        scl_m = 1'b1; tick(QTR);
        sda_m = 1'b0; tick(QTR);
        scl_m = 1'b0; tick(QTR);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; tick(QTR);
        scl_m = 1'b1; tick(QTR);
        sda_m = 1'b1; tick(QTR);
    endtask

    // One bit clock; the line is sampled early and late in the high phase.
    task automatic m_bit(input logic b, output logic r);
        logic early;
        sda_m = b; tick(QTR);
        scl_m = 1'b1; tick(2);
        early = sda_line; tick(QTR - 2);
        r = sda_line;
        if (early !== r) hold_err++;
        tick(QTR);
        scl_m = 1'b0; tick(QTR);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(b[i], r);
        m_bit(1'b1, r);
        acked = ~r;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            d[i] = r;
        end
        m_bit(~ack, r);
    endtask

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] d0;
        logic [7:0] d1;
        logic       sp;
        logic [4:0] i0;
        logic [4:0] i1;
        logic       wr;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{8'h86, 8'h11, 8'h22, 1'b0, 5'd3,  5'd4, 1'b1},
        '{8'hCA, 8'h33, 8'h44, 1'b1, 5'd5,  5'd6, 1'b1},
        '{8'h8E, 8'h55, 8'h66, 1'b0, 5'd7,  5'd0, 1'b1},
        '{8'hFE, 8'h77, 8'h88, 1'b1, 5'd31, 5'd0, 1'b1},
        '{8'h04, 8'h99, 8'hAA, 1'b0, 5'd2,  5'd3, 1'b0},
        '{8'h42, 8'hBB, 8'hCC, 1'b1, 5'd1,  5'd2, 1'b0}
    };

    function automatic logic [7:0] loc_val(input logic sp, input logic [4:0] i);
        return sp ? mdl_ram[i] : mdl_clk[i];
    endfunction

    function automatic logic [7:0] preset(input logic sp, input logic [4:0] i);
        return sp ? (8'h80 + 8'(i)) : (8'h40 + 8'(i));
    endfunction

    initial begin
        logic       a;
        logic [7:0] d;
        tick(4);
        // R1: idle outputs in reset and right after release.
        chk("R1", "oe in reset", 32'(sda_oe_o), 32'd0);
        rst_n = 1'b1;
        tick(4);
        chk("R1", "oe after reset", 32'(sda_oe_o), 32'd0);
        chk("R1", "strobes after reset", 32'({reg_wr_o, reg_rd_o}), 32'd0);

        // Vector walk: address, command, two-byte write burst (R4 R5 R6 R7).
        for (int v = 0; v < NVEC; v++) begin
            clear_model();
            m_start();
            send_byte(8'hD0, a);  chk("R3", "address ack", 32'(a), 32'd1);
            send_byte(VEC[v].cmd, a); chk("R4", "command ack", 32'(a), 32'd1);
            send_byte(VEC[v].d0, a); chk("R5", "data0 ack", 32'(a), 32'd1);
            send_byte(VEC[v].d1, a); chk("R5", "data1 ack", 32'(a), 32'd1);
            m_stop();
            tick(2);
            chk(VEC[v].wr ? "R5" : "R6", "write count", 32'(wr_cnt),
                VEC[v].wr ? 32'd2 : 32'd0);
            chk(VEC[v].wr ? "R4" : "R6", "first location",
                32'(loc_val(VEC[v].sp, VEC[v].i0)),
                VEC[v].wr ? 32'(VEC[v].d0) : 32'(preset(VEC[v].sp, VEC[v].i0)));
            chk(VEC[v].wr ? "R7" : "R6", "second location",
                32'(loc_val(VEC[v].sp, VEC[v].i1)),
                VEC[v].wr ? 32'(VEC[v].d1) : 32'(preset(VEC[v].sp, VEC[v].i1)));
        end

        // R8 R9: command read of clock 2 and 3, master NACK ends the read.
        clear_model();
        m_start();
        send_byte(8'hD0, a);
        send_byte(8'h85, a); chk("R8", "read command ack", 32'(a), 32'd1);
        recv_byte(1'b1, d);  chk("R8", "read clock 2", 32'(d), 32'h42);
        recv_byte(1'b0, d);  chk("R9", "read clock 3 after ack", 32'(d), 32'h43);
        chk("R9", "sda released after nack", 32'(sda_oe_o), 32'd0);
        m_stop();

        // R10: address with read direction resumes at index 4.
        m_start();
        send_byte(8'hD1, a); chk("R10", "read address ack", 32'(a), 32'd1);
        recv_byte(1'b0, d);  chk("R10", "resume read clock 4", 32'(d), 32'h44);
        m_stop();

        // R7 R8: RAM read from 31 wraps to 0.
        m_start();
        send_byte(8'hD0, a);
        send_byte(8'hFF, a);
        recv_byte(1'b1, d);  chk("R8", "read ram 31", 32'(d), 32'h9F);
        recv_byte(1'b0, d);  chk("R7", "read ram wraps to 0", 32'(d), 32'h80);
        m_stop();

        // R3: foreign address is never acknowledged and causes no access.
        clear_model();
        m_start();
        send_byte(8'hA0, a); chk("R3", "foreign address nack", 32'(a), 32'd0);
        send_byte(8'h86, a); chk("R3", "ignored byte nack", 32'(a), 32'd0);
        send_byte(8'h5A, a);
        m_stop();
        tick(2);
        chk("R3", "no writes for foreign address", 32'(wr_cnt), 32'd0);
        chk("R3", "sda never driven", 32'(oe_seen), 32'd0);

        // R2: repeated START in mid-byte drops the partial byte.
        clear_model();
        m_start();
        send_byte(8'hD0, a);
        send_byte(8'h86, a);
        for (int i = 0; i < 4; i++) m_bit(1'b1, a);
        m_start();
        send_byte(8'hD0, a); chk("R2", "address ack after restart", 32'(a), 32'd1);
        send_byte(8'h8A, a);
        send_byte(8'h5A, a);
        m_stop();
        tick(2);
        chk("R2", "one write after restart", 32'(wr_cnt), 32'd1);
        chk("R2", "clock 3 untouched", 32'(mdl_clk[3]), 32'h43);
        chk("R2", "clock 5 written", 32'(mdl_clk[5]), 32'h5A);

        // R2: STOP in mid-byte gives no write.
        clear_model();
        m_start();
        send_byte(8'hD0, a);
        send_byte(8'h86, a);
        for (int i = 0; i < 3; i++) m_bit(1'b0, a);
        m_stop();
        tick(2);
        chk("R2", "no write after stop", 32'(wr_cnt), 32'd0);
        chk("R2", "released after stop", 32'(sda_oe_o), 32'd0);

        // R5 R7: ten-byte RAM burst from index 28 wraps past 31.
        clear_model();
        m_start();
        send_byte(8'hD0, a);
        send_byte(8'hF8, a);
        for (int k = 0; k < 10; k++) send_byte(8'h10 + 8'(k), a);
        m_stop();
        tick(2);
        chk("R5", "burst write count", 32'(wr_cnt), 32'd10);
        chk("R7", "ram 31 in burst", 32'(mdl_ram[31]), 32'h13);
        chk("R7", "ram 5 after wrap", 32'(mdl_ram[5]), 32'h19);
        chk("R7", "ram 6 untouched", 32'(mdl_ram[6]), 32'h86);

        // R11: SDA never changed during any SCL high phase of a bit.
        chk("R11", "sda stable while scl high", 32'(hold_err), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule